// File: doc/BRIEF.md
# Circular Instruction Ring Controller

This block keeps the instruction stream of one valve in a circular queue of instruction-width entries. Instructions come in from the fabric over a valid/ready port and join the tail of the ring. The entry at the head is the execution point. It is offered to an execution datapath through a valid/done handshake. When the datapath reports completion, the block decides from the count and requeue fields whether the instruction leaves the ring, stays at the head with a smaller count, or moves to the tail.

Three ring-management instructions are handled in-band. A clog that reaches the head stops all execution. An unclog is held at the insertion point, the slot just after the execution point, until a clog sits at the head; then both leave in the same cycle. A kill is also held at the insertion point. It removes non-clog head entries one per cycle, and its own count sets how many. While a kill or unclog is held there, nothing else can enter. An unclog with no clog ahead of it therefore blocks the input for good. Data movement and packet building belong to the datapath, not to this block.

Top module: `instr_ring`

## Requirements
- R1: After reset, occupancy is 0, exec_valid is 0, blocked is 0, and in_ready is 1.
- R2: The opcode is in bits [15:14] (00 normal, 01 literal, 10 kill, 11 gate). Normal, literal and gate instructions enter the ring in arrival order, and the head is presented on exec_instr. in_ready is low for them while DEPTH entries are occupied.
- R3: A normal instruction whose count field (bits [6:0]) is 0 leaves the ring after one completed execution.
- R4: A normal instruction with bit 13 clear and count n, where 0 < n < 127, stays at the head. Each completed execution lowers its count by one, so it runs n+1 times before it leaves.
- R5: A normal instruction with bit 13 set and a count above 0 moves to the tail after execution, with its count lowered by one.
- R6: Count 127 marks a standing instruction. Its count never changes: with bit 13 clear it repeats at the head, and with bit 13 set it circulates.
- R7: A literal instruction leaves the ring after one completed execution, whatever its count field holds.
- R8: A gate instruction with bit 13 clear (a clog) at the head keeps exec_valid low. It also keeps every entry behind it in place.
- R9: A gate instruction with bit 13 set (an unclog) is accepted into the insertion point and does not occupy a slot. It sets blocked and drops in_ready. Once a clog is at the head, the clog and the unclog leave together on one edge. With no clog in the ring, blocked and the low in_ready persist.
- R10: A kill with count k is accepted into the insertion point and sets blocked. From the next edge it removes one non-clog head entry per cycle, k+1 in total, and exec_valid stays low meanwhile. After the last removal, blocked clears.
- R11: A requeue has priority on a full ring. Occupancy stays at DEPTH and in_ready stays low. On a ring that is not full, a requeue and a new insertion may complete in the same cycle, and the requeued entry lands ahead of the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| in_valid | input | 1 | Fabric offers an instruction |
| in_instr | input | IW | Offered instruction |
| in_ready | output | 1 | Instruction accepted on this edge when valid |
| exec_valid | output | 1 | Head instruction may be executed |
| exec_instr | output | IW | Head instruction, with its current count |
| exec_done | input | 1 | Datapath finished the head instruction |
| occupancy | output | clog2(DEPTH+1) | Number of occupied ring entries |
| blocked | output | 1 | A kill or unclog is held at the insertion point |

## Verification
The colliding pair is the completion of a requeueing head instruction and a fresh insertion from the fabric on the same edge. Both write the tail, and on a full ring they also compete for the single slot the head frees. The bench drives exec_done and in_valid on the same negative edge, once with the ring full and once with it partly filled. It then judges the result from the occupancy, in_ready, and the order in which the tagged instructions come back to the head.

// File: rtl/iring_pkg.sv
package iring_pkg;
  localparam logic [1:0] OP_NORM = 2'b00;
  localparam logic [1:0] OP_LIT  = 2'b01;
  localparam logic [1:0] OP_KILL = 2'b10;
  localparam logic [1:0] OP_GATE = 2'b11;

  typedef enum logic [1:0] {
    PD_NONE   = 2'b00,
    PD_KILL   = 2'b01,
    PD_UNCLOG = 2'b10
  } pend_e;
endpackage

// File: rtl/instr_ring_store.sv
module instr_ring_store #(
  parameter int DEPTH = 8,
  parameter int IW    = 16,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          rq_en,
  input  logic [IW-1:0] rq_data,
  input  logic          ins_en,
  input  logic [IW-1:0] ins_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_data,
  output logic [IW-1:0] head_data,
  output logic [OW-1:0] occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int XW = OW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] hd_q, hd_d;
  logic [OW-1:0] occ_q, occ_d;
  logic [XW-1:0] base_a, base_b;
  logic [PW-1:0] slot_a, slot_b;

  // tail slots: requeued entry first, fresh entry after it
  always_comb begin
    base_a = XW'(hd_q) + XW'(occ_q);
    base_b = base_a + XW'(rq_en);
    slot_a = (base_a >= XW'(DEPTH)) ? PW'(base_a - XW'(DEPTH)) : PW'(base_a);
    slot_b = (base_b >= XW'(DEPTH)) ? PW'(base_b - XW'(DEPTH)) : PW'(base_b);
    hd_d   = (hd_q == LAST) ? '0 : hd_q + PW'(1);
    occ_d  = occ_q + OW'(rq_en) + OW'(ins_en) - OW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (pop) hd_q <= hd_d;
      if (pop || rq_en || ins_en) occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) mem[hd_q]   <= upd_data;
    if (rq_en)  mem[slot_a] <= rq_data;
    if (ins_en) mem[slot_b] <= ins_data;
  end

  assign head_data = mem[hd_q];
  assign occ       = occ_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));

  assert_full_requeue_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OW'(DEPTH) && rq_en) |=> (occ_q == OW'(DEPTH)));
endmodule

// File: rtl/instr_ring_ctrl.sv
module instr_ring_ctrl
  import iring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = 16,
  parameter int CW    = 7,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_instr,
  input  logic          exec_done,
  input  logic [IW-1:0] head_instr,
  input  logic [OW-1:0] occ,
  output logic          in_ready,
  output logic          exec_valid,
  output logic          blocked,
  output logic          pop,
  output logic          rq_en,
  output logic [IW-1:0] rq_data,
  output logic          ins_en,
  output logic [IW-1:0] ins_data,
  output logic          upd_en,
  output logic [IW-1:0] upd_data
);
  localparam int SUB = IW - 3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  pend_e         pend_q, pend_d;
  logic [CW-1:0] kcnt_q, kcnt_d;
  logic          kcnt_en;

  logic [1:0]    h_op, in_op;
  logic          h_sub, have, h_clog, in_side, full;
  logic [CW-1:0] h_cnt, cnt_next;
  logic          fire, fire_norm, retire, requeue, repeat_hd;
  logic          kill_hit, unclog_hit, acc;
  logic [IW-1:0] new_head;

  always_comb begin
    h_op    = head_instr[IW-1:IW-2];
    h_sub   = head_instr[SUB];
    h_cnt   = head_instr[CW-1:0];
    have    = (occ != '0);
    h_clog  = have && (h_op == OP_GATE) && !h_sub;
    in_op   = in_instr[IW-1:IW-2];
    in_side = (in_op == OP_KILL) || ((in_op == OP_GATE) && in_instr[SUB]);
    full    = (occ == OW'(DEPTH));

    exec_valid = have && !h_clog && (pend_q != PD_KILL);
    fire       = exec_valid && exec_done;
    fire_norm  = fire && (h_op == OP_NORM);
    retire     = fire && ((h_op != OP_NORM) || (h_cnt == '0));
    requeue    = fire_norm && (h_cnt != '0) && h_sub;
    repeat_hd  = fire_norm && (h_cnt != '0) && !h_sub;
    cnt_next   = (h_cnt == CMAX) ? h_cnt : h_cnt - CW'(1);
    new_head   = {head_instr[IW-1:CW], cnt_next};

    kill_hit   = (pend_q == PD_KILL) && have && !h_clog;
    unclog_hit = (pend_q == PD_UNCLOG) && h_clog;

    in_ready = (pend_q == PD_NONE) && (in_side || !full);
    acc      = in_valid && in_ready;
  end

  assign pop      = retire || requeue || kill_hit || unclog_hit;
  assign rq_en    = requeue;
  assign rq_data  = new_head;
  assign upd_en   = repeat_hd;
  assign upd_data = new_head;
  assign ins_en   = acc && !in_side;
  assign ins_data = in_instr;
  assign blocked  = (pend_q != PD_NONE);

  // insertion-point state: next-state logic
  always_comb begin
    pend_d  = pend_q;
    kcnt_d  = kcnt_q;
    kcnt_en = 1'b0;
    if (acc && in_side) begin
      pend_d  = (in_op == OP_KILL) ? PD_KILL : PD_UNCLOG;
      kcnt_d  = in_instr[CW-1:0];
      kcnt_en = 1'b1;
    end else if (kill_hit) begin
      if (kcnt_q == '0) begin
        pend_d = PD_NONE;
      end else begin
        kcnt_d  = kcnt_q - CW'(1);
        kcnt_en = 1'b1;
      end
    end else if (unclog_hit) begin
      pend_d = PD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_NONE;
      kcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (kcnt_en) kcnt_q <= kcnt_d;
    end
  end

  assert_clog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_clog && pend_q != PD_UNCLOG) |=> (occ >= $past(occ)));

  assert_unclog_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unclog_hit |=> (pend_q == PD_NONE && occ + OW'(1) == $past(occ)));

  assert_kill_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill_hit |=> (occ + OW'(1) == $past(occ)));

  assert_repeat_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_norm && !h_sub && h_cnt != '0 && h_cnt != CMAX)
      |=> (head_instr[CW-1:0] + CW'(1) == $past(h_cnt)));

  assert_standing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_norm && !h_sub && h_cnt == CMAX) |=> (head_instr == $past(head_instr)));
endmodule

// File: rtl/instr_ring.sv
module instr_ring #(
  parameter int DEPTH = 8,
  parameter int IW    = 16,
  parameter int CW    = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [IW-1:0]                in_instr,
  output logic                         in_ready,
  output logic                         exec_valid,
  output logic [IW-1:0]                exec_instr,
  input  logic                         exec_done,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy,
  output logic                         blocked
);
  localparam int OW = $clog2(DEPTH + 1);

  logic          pop, rq_en, ins_en, upd_en;
  logic [IW-1:0] rq_data, ins_data, upd_data, head;
  logic [OW-1:0] occ;

  instr_ring_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW), .OW(OW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_instr(in_instr), .exec_done(exec_done),
    .head_instr(head), .occ(occ),
    .in_ready(in_ready), .exec_valid(exec_valid), .blocked(blocked),
    .pop(pop), .rq_en(rq_en), .rq_data(rq_data),
    .ins_en(ins_en), .ins_data(ins_data),
    .upd_en(upd_en), .upd_data(upd_data)
  );

  instr_ring_store #(.DEPTH(DEPTH), .IW(IW), .OW(OW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pop(pop), .rq_en(rq_en), .rq_data(rq_data),
    .ins_en(ins_en), .ins_data(ins_data),
    .upd_en(upd_en), .upd_data(upd_data),
    .head_data(head), .occ(occ)
  );

  assign exec_instr = head;
  assign occupancy  = occ;
endmodule

// File: tb/instr_ring_test.sv
module instr_ring_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, exec_done;
  logic [15:0] in_instr;
  logic        in_ready, exec_valid, blocked;
  logic [15:0] exec_instr;
  logic [3:0]  occupancy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  instr_ring #(.DEPTH(DEPTH), .IW(16), .CW(7)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_instr(in_instr), .in_ready(in_ready),
    .exec_valid(exec_valid), .exec_instr(exec_instr), .exec_done(exec_done),
    .occupancy(occupancy), .blocked(blocked)
  );

  function automatic logic [15:0] mk(input int op, input int sub, input int cnt, input int tag);
    logic [1:0] o = op[1:0];
    logic       s = sub[0];
    logic [5:0] t = tag[5:0];
    logic [6:0] c = cnt[6:0];
    return {o, s, t, c};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] x);
    in_valid = 1'b1;
    in_instr = x;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic done1();
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; exec_done = 1'b0; in_instr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 occ", occupancy, 0);
    check("R1 exec_valid", exec_valid, 0);
    check("R1 blocked", blocked, 0);
    check("R1 in_ready", in_ready, 1);

    // R2 / R3: order of arrival, single execution at count 0
    for (int j = 1; j <= 3; j++) put(mk(0, 0, 0, j));
    check("R2 occ", occupancy, 3);
    for (int j = 1; j <= 3; j++) begin
      check("R2 head order", exec_instr[12:7], j);
      check("R2 exec_valid", exec_valid, 1);
      done1();
      check("R3 retire", occupancy, 3 - j);
    end

    // R4: repeat in place, sweep of counts
    for (int n = 0; n <= 4; n++) begin
      put(mk(0, 0, n, 8 + n));
      for (int i = 0; i <= n; i++) begin
        check("R4 count", exec_instr[6:0], n - i);
        check("R4 occ", occupancy, 1);
        done1();
      end
      check("R4 leaves", occupancy, 0);
    end

    // R5: requeue to the tail
    put(mk(0, 1, 2, 10));
    put(mk(0, 0, 0, 11));
    done1();
    check("R5 next head", exec_instr[12:7], 11);
    check("R5 occ", occupancy, 2);
    done1();
    check("R5 requeued tag", exec_instr[12:7], 10);
    check("R5 requeued count", exec_instr[6:0], 1);
    done1();
    check("R5 count again", exec_instr[6:0], 0);
    done1();
    check("R5 drained", occupancy, 0);

    // R6: standing in place, then circulating
    put(mk(0, 0, 127, 12));
    for (int i = 0; i < 3; i++) done1();
    check("R6 repeat count", exec_instr[6:0], 127);
    check("R6 repeat occ", occupancy, 1);
    put(mk(2, 0, 0, 0));          // kill one
    @(negedge clk);
    check("R6 cleared", occupancy, 0);
    put(mk(0, 1, 127, 13));
    put(mk(0, 0, 0, 14));
    done1();
    check("R6 circulate head", exec_instr[12:7], 14);
    done1();
    check("R6 circulate tag", exec_instr[12:7], 13);
    check("R6 circulate count", exec_instr[6:0], 127);
    put(mk(2, 0, 0, 0));
    @(negedge clk);
    check("R6 circulate cleared", occupancy, 0);

    // R7: literal retires once
    put(mk(1, 0, 5, 15));
    done1();
    check("R7 literal", occupancy, 0);

    // R2 / R11: full ring with a requeue at the head
    put(mk(0, 1, 3, 20));
    for (int j = 21; j <= 27; j++) put(mk(0, 0, 0, j));
    check("R2 full occ", occupancy, DEPTH);
    check("R2 full ready", in_ready, 0);
    in_valid = 1'b1; in_instr = mk(0, 0, 0, 40);
    done1();                        // requeue and offered insert together
    in_valid = 1'b0;
    check("R11 full occ", occupancy, DEPTH);
    check("R11 full ready", in_ready, 0);
    check("R11 head after", exec_instr[12:7], 21);
    for (int j = 0; j < 7; j++) done1();
    check("R11 requeued head", exec_instr[12:7], 20);
    check("R11 requeued count", exec_instr[6:0], 2);
    check("R11 occ", occupancy, 1);
    for (int j = 0; j < 3; j++) done1();
    check("R11 drained", occupancy, 0);
    put(mk(0, 1, 1, 30));
    in_valid = 1'b1; in_instr = mk(0, 0, 0, 31); exec_done = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; exec_done = 1'b0;
    check("R11 both occ", occupancy, 2);
    check("R11 both head", exec_instr[12:7], 30);
    check("R11 both count", exec_instr[6:0], 0);
    done1();
    check("R11 new after requeue", exec_instr[12:7], 31);
    done1();
    check("R11 empty", occupancy, 0);

    // R8 / R9: clog stall and unclog rendezvous
    put(mk(3, 0, 0, 0));
    put(mk(0, 0, 0, 41));
    check("R8 stall valid", exec_valid, 0);
    exec_done = 1'b1;
    repeat (3) @(negedge clk);
    exec_done = 1'b0;
    check("R8 stall occ", occupancy, 2);
    put(mk(3, 1, 0, 0));
    check("R9 held blocked", blocked, 1);
    check("R9 held occ", occupancy, 2);
    @(negedge clk);
    check("R9 released", blocked, 0);
    check("R9 pair leaves", occupancy, 1);
    check("R9 next valid", exec_valid, 1);
    check("R9 next tag", exec_instr[12:7], 41);
    done1();

    // R10: kill sweep
    for (int k = 0; k <= 3; k++) begin
      for (int j = 0; j < 5; j++) put(mk(0, 0, 0, 50 + j));
      put(mk(2, 0, k, 0));
      check("R10 blocked", blocked, 1);
      check("R10 valid off", exec_valid, 0);
      for (int i = 0; i <= k; i++) begin
        @(negedge clk);
        check("R10 occ", occupancy, 4 - i);
        check("R10 blocked step", blocked, (i < k) ? 1 : 0);
      end
      check("R10 survivor", exec_instr[12:7], 51 + k);
      for (int j = 0; j < 4 - k; j++) done1();
      check("R10 drained", occupancy, 0);
    end

    // R9: unclog without a clog blocks the input for good
    put(mk(3, 1, 0, 0));
    in_instr = mk(0, 0, 0, 60);
    repeat (10) @(negedge clk);
    check("R9 stuck blocked", blocked, 1);
    check("R9 stuck ready", in_ready, 0);
    check("R9 stuck occ", occupancy, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule